// File: doc/BRIEF.md
# FPGA Configuration Load Sequencer

This block brings a slave FPGA through its configuration cycle. A start request selects one of two targets (main or mezzanine). If the chosen target has configuration space, the block runs the whole pin sequence. It raises an optional enable pin and releases the open-drain INIT line. It then pulses PROGRAM low for a fixed width and waits, with a timeout, for the slave to pull INIT high. After that it forwards the configuration image one byte per write and waits, with a longer timeout, for DONE.

The image arrives on a byte-wide valid/ready stream, and the byte count is latched at start. Completion is marked by a one-cycle `done_o` pulse and a 2-bit result code. The code stays readable until the next start. INIT and DONE are asynchronous to the block and pass through a two-flop synchronizer.

Top module: `cfg_load_seq`

## Requirements
- R1: A start whose selected target has its `cfg_present_i` bit clear produces `done_o` on the following clock edge with `result_o` = 1. `busy_o` never rises, no write occurs, and PROGRAM, ENABLE and the INIT output-enable keep their values.
- R2: When the selected target's `en_used_i` bit is set, `enable_o` is high before PROGRAM falls and is low when `done_o` pulses, on success and on every failure. When the bit is clear, `enable_o` stays low.
- R3: `init_oe_o` (1 = drive INIT low) is already 0 on the cycle before `prog_n_o` falls.
- R4: `prog_n_o` is low for exactly `PROG_LOW_CYC` consecutive cycles per load, and falls once per load.
- R5: If synchronized INIT is not high within `INIT_TO_CYC` cycles of PROGRAM rising, the load ends with `result_o` = 2 exactly `INIT_TO_CYC` cycles after the rise, and no write occurs.
- R6: Once INIT is high, each accepted stream handshake gives one `cfg_we_o` pulse with that byte on `cfg_data_o`. Bytes leave in arrival order, and there are exactly `byte_count_i` writes.
- R7: If synchronized DONE is not high within `10*INIT_TO_CYC` cycles of the last write, the load ends with `result_o` = 3 exactly that many cycles after the last write.
- R8: When DONE rises within its timeout, the load ends with `result_o` = 0.
- R9: After reset, `init_oe_o` is 1 (INIT held low), `prog_n_o` is 1, and `enable_o`, `busy_o`, `done_o` and `result_o` are 0. INIT stays held until a load starts.
- R10: A start while busy is ignored, and each load gives exactly one `done_o` pulse. `result_o` is unchanged from that pulse until the next start.
- R11: A byte count of zero skips the data phase: no write occurs and the block goes straight to waiting for DONE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a load (sampled while idle) |
| tgt_sel_i | input | 1 | Target select: 0 main, 1 mezzanine |
| cfg_present_i | input | 2 | Per-target configuration-space-present flags |
| en_used_i | input | 2 | Per-target flag: drive the enable pin during a load |
| byte_count_i | input | CNT_W | Image length in bytes, latched at start |
| s_valid_i | input | 1 | Image byte valid |
| s_data_i | input | DATA_W | Image byte |
| s_ready_o | output | 1 | Block accepts an image byte |
| prog_n_o | output | 1 | PROGRAM pin, active low |
| init_oe_o | output | 1 | INIT open-drain enable, 1 pulls INIT low |
| init_i | input | 1 | INIT pin level |
| done_i | input | 1 | DONE pin level |
| enable_o | output | 1 | Optional slave enable pin |
| cfg_we_o | output | 1 | Configuration write strobe |
| cfg_data_o | output | DATA_W | Configuration write data |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 ok, 1 no config space, 2 INIT timeout, 3 DONE timeout |

## Verification
The hardest cases to reach from the ports are the two timeout exits, and their exact expiry cycles. A slave model in the bench reacts to PROGRAM with a programmable INIT delay and a programmable DONE delay after the last byte, and either delay can be set to never. The bench then measures the distance from the PROGRAM rise, or from the last write, to the completion pulse. A sweep over targets, image lengths from zero up, slave delays and stream gaps covers the success path. A second start issued in the middle of a load exercises the ignore rule.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;

  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_NOCFG  = 2'd1,
    RES_NOINIT = 2'd2,
    RES_NODONE = 2'd3
  } load_res_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_PROG,
    S_WINIT,
    S_STREAM,
    S_WDONE
  } seq_state_e;

endpackage

// File: rtl/cls_sync2.sv
module cls_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cls_down_ctr.sv
module cls_down_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         zero
);
  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (dec && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
  import cfg_load_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int CNT_W        = 16,
  parameter int PROG_LOW_CYC = 20,
  parameter int INIT_TO_CYC  = 10000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              tgt_sel_i,
  input  logic [1:0]        cfg_present_i,
  input  logic [1:0]        en_used_i,
  input  logic [CNT_W-1:0]  byte_count_i,
  input  logic              s_valid_i,
  input  logic [DATA_W-1:0] s_data_i,
  output logic              s_ready_o,
  output logic              prog_n_o,
  output logic              init_oe_o,
  input  logic              init_i,
  input  logic              done_i,
  output logic              enable_o,
  output logic              cfg_we_o,
  output logic [DATA_W-1:0] cfg_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        result_o
);
  localparam int DONE_TO_CYC = 10 * INIT_TO_CYC;
  localparam int TMR_W       = $clog2(DONE_TO_CYC + 1);

  seq_state_e state;

  // pin synchronizer
  logic [1:0] pins_s;
  logic       init_s, done_s;

  cls_sync2 #(.W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({done_i, init_i}),
    .q   (pins_s)
  );
  assign init_s = pins_s[0];
  assign done_s = pins_s[1];

  // shared phase timer: PROGRAM width, INIT timeout, DONE timeout
  logic             tmr_load, tmr_dec, tmr_zero;
  logic [TMR_W-1:0] tmr_val, tmr_cnt;

  cls_down_ctr #(.W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .cnt      (tmr_cnt),
    .zero     (tmr_zero)
  );

  // remaining image bytes
  logic             bc_load, bc_dec, bc_zero;
  logic [CNT_W-1:0] bc_cnt;

  cls_down_ctr #(.W(CNT_W)) u_bytes (
    .clk      (clk),
    .rst      (rst),
    .load     (bc_load),
    .load_val (byte_count_i),
    .dec      (bc_dec),
    .cnt      (bc_cnt),
    .zero     (bc_zero)
  );

  logic hs;
  logic last_byte;
  logic tgt_ok;

  assign s_ready_o = (state == S_STREAM);
  assign hs        = s_ready_o && s_valid_i;
  assign last_byte = (bc_cnt == CNT_W'(1));
  assign tgt_ok    = cfg_present_i[tgt_sel_i];

  // counter control
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    tmr_dec  = 1'b0;
    bc_load  = 1'b0;
    bc_dec   = 1'b0;
    case (state)
      S_IDLE: begin
        if (start_i && tgt_ok) bc_load = 1'b1;
      end
      S_SETUP: begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(PROG_LOW_CYC - 1);
      end
      S_PROG: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(INIT_TO_CYC - 1);
        end else begin
          tmr_dec = 1'b1;
        end
      end
      S_WINIT: begin
        if (init_s) begin
          if (bc_zero) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(DONE_TO_CYC - 1);
          end
        end else begin
          tmr_dec = 1'b1;
        end
      end
      S_STREAM: begin
        if (hs) begin
          bc_dec = 1'b1;
          if (last_byte) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(DONE_TO_CYC - 1);
          end
        end
      end
      S_WDONE: begin
        if (!done_s) tmr_dec = 1'b1;
      end
      default: ;
    endcase
  end

  // sequence and registered pins
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      result_o   <= RES_OK;
      prog_n_o   <= 1'b1;
      init_oe_o  <= 1'b1;
      enable_o   <= 1'b0;
      cfg_we_o   <= 1'b0;
      cfg_data_o <= '0;
    end else begin
      done_o   <= 1'b0;
      cfg_we_o <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start_i) begin
            if (!tgt_ok) begin
              done_o   <= 1'b1;
              result_o <= RES_NOCFG;
            end else begin
              busy_o    <= 1'b1;
              enable_o  <= en_used_i[tgt_sel_i];
              init_oe_o <= 1'b0;
              state     <= S_SETUP;
            end
          end
        end
        S_SETUP: begin
          prog_n_o <= 1'b0;
          state    <= S_PROG;
        end
        S_PROG: begin
          if (tmr_zero) begin
            prog_n_o <= 1'b1;
            state    <= S_WINIT;
          end
        end
        S_WINIT: begin
          if (init_s) begin
            state <= bc_zero ? S_WDONE : S_STREAM;
          end else if (tmr_zero) begin
            state    <= S_IDLE;
            busy_o   <= 1'b0;
            done_o   <= 1'b1;
            enable_o <= 1'b0;
            result_o <= RES_NOINIT;
          end
        end
        S_STREAM: begin
          if (hs) begin
            cfg_we_o   <= 1'b1;
            cfg_data_o <= s_data_i;
            if (last_byte) state <= S_WDONE;
          end
        end
        S_WDONE: begin
          if (done_s || tmr_zero) begin
            state    <= S_IDLE;
            busy_o   <= 1'b0;
            done_o   <= 1'b1;
            enable_o <= 1'b0;
            result_o <= done_s ? RES_OK : RES_NODONE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // assertions
  p_nocfg_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && start_i && !tgt_ok) |=>
      (done_o && result_o == RES_NOCFG && !busy_o && prog_n_o && !cfg_we_o));

  p_enable_exit_r2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !enable_o);

  p_release_first_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(prog_n_o) |-> (!init_oe_o && $past(!init_oe_o)));

  p_no_write_on_noinit_r5: assert property (@(posedge clk) disable iff (rst)
    (done_o && result_o == RES_NOINIT) |-> !cfg_we_o);

  p_write_from_handshake_r6: assert property (@(posedge clk) disable iff (rst)
    cfg_we_o |-> $past(s_ready_o && s_valid_i));

  p_single_done_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !done_o && !start_i) |=> $stable(result_o));

  p_idle_pins_r9: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (prog_n_o && !s_ready_o));

endmodule

// File: tb/sim_cfg_load_seq.sv
module sim_cfg_load_seq;
  localparam int PL = 5;
  localparam int IT = 12;
  localparam int DT = 10 * IT;
  localparam int NEVER = 255;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        start_i = 1'b0, tgt_sel_i = 1'b0;
  logic [1:0]  cfg_present_i = 2'b00, en_used_i = 2'b00;
  logic [15:0] byte_count_i = '0;
  logic        s_valid_i = 1'b0;
  logic [7:0]  s_data_i = '0;
  logic        s_ready_o, prog_n_o, init_oe_o, init_i, done_i, enable_o;
  logic        cfg_we_o, busy_o, done_o;
  logic [7:0]  cfg_data_o;
  logic [1:0]  result_o;

  int checks = 0, errors = 0;
  int cyc = 0;
  int run_count = 0, d_init = 0, d_done = 0, gap = 0, seed = 0;
  int fell_cnt = 0, prog_len = 0, prog_rise_cyc = 0, we_cnt = 0, data_bad = 0;
  int last_we_cyc = 0, done_pulses = 0, done_cyc = 0, ic = 0, dc = 0;
  bit prev_low = 0, oe_at_fall = 0, en_at_fall = 0, en_at_done = 0, en_ever = 0;
  bit sl_init = 1, sl_done = 0;

  assign init_i = init_oe_o ? 1'b0 : sl_init;
  assign done_i = sl_done;

  cfg_load_seq #(.DATA_W(8), .CNT_W(16), .PROG_LOW_CYC(PL), .INIT_TO_CYC(IT)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .tgt_sel_i(tgt_sel_i),
    .cfg_present_i(cfg_present_i), .en_used_i(en_used_i), .byte_count_i(byte_count_i),
    .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_ready_o(s_ready_o),
    .prog_n_o(prog_n_o), .init_oe_o(init_oe_o), .init_i(init_i), .done_i(done_i),
    .enable_o(enable_o), .cfg_we_o(cfg_we_o), .cfg_data_o(cfg_data_o),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  function automatic logic [7:0] exp_byte(int s, int k);
    return 8'((s * 13 + k * 37 + 5) & 255);
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor, slave model and stream driver, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (!prog_n_o) begin
        if (!prev_low) begin
          fell_cnt++;
          oe_at_fall = init_oe_o;
          en_at_fall = enable_o;
        end
        prog_len++;
      end else if (prev_low) begin
        prog_rise_cyc = cyc;
      end
      prev_low = !prog_n_o;
      if (enable_o) en_ever = 1;
      if (cfg_we_o) begin
        if (cfg_data_o !== exp_byte(seed, we_cnt)) data_bad++;
        we_cnt++;
        last_we_cyc = cyc;
      end
      if (done_o) begin
        done_pulses++;
        done_cyc = cyc;
        en_at_done = enable_o;
      end
      // slave FPGA model
      if (!prog_n_o) begin
        sl_init = 0; sl_done = 0; ic = 0; dc = 0;
      end else begin
        if (!sl_init && d_init != NEVER) begin
          if (ic >= d_init) sl_init = 1; else ic++;
        end
        if (sl_init && !sl_done && d_done != NEVER && we_cnt == run_count) begin
          if (dc >= d_done) sl_done = 1; else dc++;
        end
      end
    end
    s_valid_i = (we_cnt < run_count) && (gap == 0 || (cyc % gap) != 0);
    s_data_i  = exp_byte(seed, we_cnt);
  end

  task automatic run(input bit tgt, input logic [1:0] pres, input logic [1:0] en,
                     input int cnt, input int di, input int dd, input int g,
                     input bit restart);
    int start_c, w, expr;
    @(posedge clk); #1;
    fell_cnt = 0; prog_len = 0; prog_rise_cyc = 0; we_cnt = 0; data_bad = 0;
    last_we_cyc = 0; done_pulses = 0; done_cyc = 0;
    oe_at_fall = 0; en_at_fall = 0; en_at_done = 0; en_ever = 0;
    tgt_sel_i = tgt; cfg_present_i = pres; en_used_i = en;
    byte_count_i = 16'(cnt); run_count = cnt;
    d_init = di; d_done = dd; gap = g; seed++;
    start_c = cyc;
    start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
    if (restart) begin
      repeat (2) @(posedge clk);
      #1 start_i = 1'b1;
      @(posedge clk); #1 start_i = 1'b0;
    end
    w = 0;
    while (done_pulses == 0 && w < 3000) begin
      @(posedge clk); w++;
    end
    check(w < 3000, "R10 watchdog: load never completed", w, 0);
    repeat (6) @(posedge clk);
    #1;
    if (!pres[tgt])          expr = 1;
    else if (di == NEVER)    expr = 2;
    else if (dd == NEVER)    expr = 3;
    else                     expr = 0;
    check(int'(result_o) == expr, "R8/R5/R7/R1 result code", int'(result_o), expr);
    check(done_pulses == 1, "R10 one done pulse per load", done_pulses, 1);
    check(!busy_o, "R10 busy low after completion", int'(busy_o), 0);
    if (expr == 1) begin
      check(done_cyc == start_c + 2, "R1 immediate completion", done_cyc, start_c + 2);
      check(fell_cnt == 0 && we_cnt == 0 && !en_ever, "R1 no pin activity",
            fell_cnt + we_cnt + int'(en_ever), 0);
    end else begin
      check(fell_cnt == 1, "R4 single PROGRAM pulse", fell_cnt, 1);
      check(prog_len == PL, "R4 PROGRAM low width", prog_len, PL);
      check(!oe_at_fall, "R3 INIT released before PROGRAM", int'(oe_at_fall), 0);
      check(en_at_fall == en[tgt], "R2 enable at PROGRAM fall", int'(en_at_fall), int'(en[tgt]));
      check(!en_at_done, "R2 enable low at exit", int'(en_at_done), 0);
      check(en_ever == en[tgt], "R2 enable use per target", int'(en_ever), int'(en[tgt]));
      if (expr == 2) begin
        check(we_cnt == 0, "R5 no data on INIT timeout", we_cnt, 0);
        check(done_cyc - prog_rise_cyc == IT, "R5 INIT timeout length",
              done_cyc - prog_rise_cyc, IT);
      end else begin
        check(we_cnt == cnt, "R6/R11 write count", we_cnt, cnt);
        check(data_bad == 0, "R6 byte order and value", data_bad, 0);
        if (expr == 3 && cnt > 0)
          check(done_cyc - last_we_cyc == DT, "R7 DONE timeout length",
                done_cyc - last_we_cyc, DT);
      end
    end
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    check(init_oe_o && !init_i, "R9 INIT held after reset", int'(init_oe_o), 1);
    check(prog_n_o && !enable_o && !busy_o && !done_o && !s_ready_o,
          "R9 idle pins after reset", int'(prog_n_o), 1);
    check(result_o == 2'd0, "R9 result after reset", int'(result_o), 0);

    // R1: missing configuration space on either target
    run(1'b0, 2'b10, 2'b11, 3, 0, 0, 0, 1'b0);
    check(init_oe_o, "R9 INIT still held after no-config start", int'(init_oe_o), 1);
    run(1'b1, 2'b01, 2'b11, 3, 0, 0, 0, 1'b0);

    // sweep of the success path
    for (int t = 0; t < 2; t++)
      for (int n = 0; n < 6; n++)
        for (int a = 0; a < 3; a++)
          for (int b = 0; b < 3; b++)
            for (int gsel = 0; gsel < 2; gsel++)
              run(t[0], 2'b11, 2'b01, n, a * 2 + (n % 2), b * 17 + n, gsel * 3, 1'b0);

    // R5: INIT never rises
    run(1'b0, 2'b11, 2'b01, 0, NEVER, 0, 0, 1'b0);
    run(1'b1, 2'b11, 2'b01, 4, NEVER, 0, 3, 1'b0);
    // R7: DONE never rises
    run(1'b0, 2'b11, 2'b01, 0, 1, NEVER, 0, 1'b0);
    run(1'b0, 2'b11, 2'b01, 2, 3, NEVER, 0, 1'b0);
    run(1'b1, 2'b11, 2'b01, 5, 0, NEVER, 3, 1'b0);
    // R10: second start while busy
    run(1'b0, 2'b11, 2'b01, 4, 2, 3, 0, 1'b1);
    run(1'b1, 2'b11, 2'b10, 1, NEVER, 0, 0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog R10: run did not end actual=%0d expected=0", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule